// File: doc/BRIEF.md
# Vector Element Insert and Pick Unit

This unit sits in a 256-bit vector execution pipe and moves one 32-bit or 64-bit element between element position 0 and a position chosen by a small immediate. The immediate indexes the whole 256-bit vector; it is not confined to one 128-bit half. In insert mode, element 0 of the source vector is written into the old destination vector at the chosen position. Every other destination element keeps its value, so the caller supplies the old destination contents as an input. In pick mode, the chosen source element lands in element 0 of the result and all other result bits are cleared.

Each operation is presented with a single-cycle `in_valid` strobe. The result is registered and appears one clock later together with `out_valid`. Reading and writing the register file belongs to the surrounding pipe. Element k of a vector occupies bits [k*W+W-1 : k*W], where W is the element width.

Top module: `vec_elem_move`

## Requirements
- R1: While `rst_n` is low and after it is released, `out_valid` is 0 and `out_result` is all zeros until the first accepted operation.
- R2: `out_valid` equals `in_valid` of the previous clock. The result of an operation accepted on a clock edge is on `out_result` in the cycle after that edge.
- R3: Word insert (`op`=0, `size`=2'b00) places `src_vec[31:0]` into element `imm[2:0]` of the result, using 8 word positions. All other words equal `old_dst`.
- R4: Doubleword insert (`op`=0, `size`=2'b01) places `src_vec[63:0]` into element `imm[1:0]`, using 4 positions. `imm[2]` has no effect. All other doublewords equal `old_dst`.
- R5: Word pick (`op`=1, `size`=2'b00) puts source word `imm[2:0]` in `out_result[31:0]` and zeros in bits 255:32. `old_dst` has no effect.
- R6: Doubleword pick (`op`=1, `size`=2'b01) puts source doubleword `imm[1:0]` in `out_result[63:0]` and zeros in bits 255:64. `imm[2]` and `old_dst` have no effect.
- R7: For the size codes 2'b10 and 2'b11, with either `op`, the result equals `old_dst` unchanged.
- R8: In a cycle where `in_valid` is 0, `out_result` keeps its previous value whatever the other inputs carry.
- R9: When the source and the old destination are the same vector, an insert is computed from the values before the update. Element 0 of that vector is copied to the indexed slot, and element 0 itself keeps its old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation strobe |
| in_op | input | 1 | 0 = insert, 1 = pick |
| in_size | input | 2 | 2'b00 = word, 2'b01 = doubleword, others unsupported |
| in_imm | input | 3 | Element index immediate |
| src_vec | input | 256 | Source vector |
| old_dst | input | 256 | Previous destination vector |
| out_valid | output | 1 | Result valid, one cycle after in_valid |
| out_result | output | 256 | Registered result vector |

## Verification
Directed cases sweep every immediate value for each op and size. Walking-pattern sources, in which each element holds a distinct value, reveal an index that is off by one or wraps wrongly. A dense old destination placed beside a different source tells a preserved lane apart from a cleared one. Doubleword cases with `imm[2]` set confirm that the index is masked to 2 bits. Idle cycles carrying garbage and an aliased source/destination separate the hold behaviour and the pre-update semantics from the main path. A long stretch of random operations with random gaps is then compared every clock against a behavioural model.

// File: rtl/vec_elem_move_pkg.sv
package vec_elem_move_pkg;
   typedef enum logic {
      OP_INSERT = 1'b0,
      OP_PICK   = 1'b1
   } move_op_e;

   typedef enum logic [1:0] {
      SZ_WORD  = 2'b00,
      SZ_DWORD = 2'b01,
      SZ_RSV2  = 2'b10,
      SZ_RSV3  = 2'b11
   } move_size_e;

   localparam int unsigned NUM_SIZES = 2;
endpackage

// File: rtl/vem_slot_insert.sv
module vem_slot_insert #(
   parameter int unsigned VEC_W  = 256,
   parameter int unsigned ELEM_W = 32,
   parameter int unsigned IDX_W  = 3
) (
   input  logic [VEC_W-1:0] base_vec,
   input  logic [ELEM_W-1:0] new_elem,
   input  logic [IDX_W-1:0] slot,
   output logic [VEC_W-1:0] merged
);
   localparam int unsigned N_ELEM = VEC_W / ELEM_W;

   if (VEC_W % ELEM_W != 0) begin : g_bad_div
      $error("vem_slot_insert: VEC_W must be a multiple of ELEM_W");
   end
   if ((1 << IDX_W) != N_ELEM) begin : g_bad_idx
      $error("vem_slot_insert: IDX_W must address exactly VEC_W/ELEM_W slots");
   end

   for (genvar e = 0; e < N_ELEM; e++) begin : g_slot
      logic hit;
      assign hit = (slot == IDX_W'(e));
      assign merged[e*ELEM_W +: ELEM_W] = hit ? new_elem : base_vec[e*ELEM_W +: ELEM_W];
   end
endmodule

// File: rtl/vem_slot_pick.sv
module vem_slot_pick #(
   parameter int unsigned VEC_W  = 256,
   parameter int unsigned ELEM_W = 32,
   parameter int unsigned IDX_W  = 3
) (
   input  logic [VEC_W-1:0] from_vec,
   input  logic [IDX_W-1:0] slot,
   output logic [VEC_W-1:0] picked
);
   localparam int unsigned N_ELEM = VEC_W / ELEM_W;

   if (VEC_W % ELEM_W != 0) begin : g_bad_div
      $error("vem_slot_pick: VEC_W must be a multiple of ELEM_W");
   end
   if ((1 << IDX_W) != N_ELEM) begin : g_bad_idx
      $error("vem_slot_pick: IDX_W must address exactly VEC_W/ELEM_W slots");
   end

   logic [N_ELEM-1:0][ELEM_W-1:0] masked;
   logic [ELEM_W-1:0] chosen;

   for (genvar e = 0; e < N_ELEM; e++) begin : g_mask
      assign masked[e] = (slot == IDX_W'(e)) ? from_vec[e*ELEM_W +: ELEM_W] : '0;
   end

   always_comb begin
      chosen = '0;
      for (int unsigned e = 0; e < N_ELEM; e++) begin
         chosen = chosen | masked[e];
      end
   end

   if (VEC_W > ELEM_W) begin : g_pad
      assign picked = {{(VEC_W-ELEM_W){1'b0}}, chosen};
   end else begin : g_nopad
      assign picked = chosen;
   end
endmodule

// File: rtl/vem_out_stage.sv
module vem_out_stage #(
   parameter int unsigned VEC_W = 256
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             take,
   input  logic [VEC_W-1:0] next_val,
   output logic             held_valid,
   output logic [VEC_W-1:0] held_val
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         held_valid <= 1'b0;
         held_val   <= '0;
      end else begin
         held_valid <= take;
         if (take) begin
            held_val <= next_val;
         end
      end
   end

   // R2
   valid_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> held_valid);
   // R8
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !take |=> ($stable(held_val) && !held_valid));
endmodule

// File: rtl/vec_elem_move.sv
module vec_elem_move
   import vec_elem_move_pkg::*;
#(
   parameter int unsigned VEC_W       = 256,
   parameter int unsigned BASE_ELEM_W = 32,
   parameter int unsigned IMM_W       = $clog2(VEC_W / BASE_ELEM_W)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic             in_op,
   input  logic [1:0]       in_size,
   input  logic [IMM_W-1:0] in_imm,
   input  logic [VEC_W-1:0] src_vec,
   input  logic [VEC_W-1:0] old_dst,
   output logic             out_valid,
   output logic [VEC_W-1:0] out_result
);
   localparam int unsigned WIDE_ELEM_W = BASE_ELEM_W << (NUM_SIZES - 1);

   if (VEC_W % WIDE_ELEM_W != 0) begin : g_bad_vec
      $error("vec_elem_move: VEC_W must hold a whole number of the widest elements");
   end
   if (VEC_W / WIDE_ELEM_W < 2) begin : g_bad_ratio
      $error("vec_elem_move: at least two of the widest elements are needed");
   end
   if (IMM_W != $clog2(VEC_W / BASE_ELEM_W)) begin : g_bad_imm
      $error("vec_elem_move: IMM_W must match the narrow element count");
   end

   logic [NUM_SIZES-1:0][VEC_W-1:0] ins_res;
   logic [NUM_SIZES-1:0][VEC_W-1:0] pick_res;

   for (genvar g = 0; g < NUM_SIZES; g++) begin : g_size
      localparam int unsigned EW = BASE_ELEM_W << g;
      localparam int unsigned IW = $clog2(VEC_W / EW);
      logic [IW-1:0] slot;
      assign slot = in_imm[IW-1:0];

      vem_slot_insert #(.VEC_W(VEC_W), .ELEM_W(EW), .IDX_W(IW)) u_ins (
         .base_vec (old_dst),
         .new_elem (src_vec[EW-1:0]),
         .slot     (slot),
         .merged   (ins_res[g])
      );

      vem_slot_pick #(.VEC_W(VEC_W), .ELEM_W(EW), .IDX_W(IW)) u_pick (
         .from_vec (src_vec),
         .slot     (slot),
         .picked   (pick_res[g])
      );
   end

   logic [VEC_W-1:0] next_res;
   always_comb begin
      unique case (move_size_e'(in_size))
         SZ_WORD:  next_res = (move_op_e'(in_op) == OP_PICK) ? pick_res[0] : ins_res[0];
         SZ_DWORD: next_res = (move_op_e'(in_op) == OP_PICK) ? pick_res[1] : ins_res[1];
         default:  next_res = old_dst;
      endcase
   end

   vem_out_stage #(.VEC_W(VEC_W)) u_out (
      .clk        (clk),
      .rst_n      (rst_n),
      .take       (in_valid),
      .next_val   (next_res),
      .held_valid (out_valid),
      .held_val   (out_result)
   );

   // R5
   word_pick_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_op && in_size == 2'b00) |=> (out_result[VEC_W-1:BASE_ELEM_W] == '0));
   // R6
   dword_pick_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_op && in_size == 2'b01) |=> (out_result[VEC_W-1:WIDE_ELEM_W] == '0));
   // R3
   word_ins_slot0_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !in_op && in_size == 2'b00 && in_imm == '0)
         |=> (out_result[BASE_ELEM_W-1:0] == $past(src_vec[BASE_ELEM_W-1:0])));
   // R3
   word_ins_keep0_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !in_op && in_size == 2'b00 && in_imm != '0)
         |=> (out_result[BASE_ELEM_W-1:0] == $past(old_dst[BASE_ELEM_W-1:0])));
   // R4
   dword_ins_top_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !in_op && in_size == 2'b01 && in_imm[1:0] == 2'b00)
         |=> (out_result[VEC_W-1:WIDE_ELEM_W] == $past(old_dst[VEC_W-1:WIDE_ELEM_W])));
   // R7
   rsv_size_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_size[1]) |=> (out_result == $past(old_dst)));
   // R2
   valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
endmodule

// File: tb/vec_elem_move_tb_top.sv
`timescale 1ns/1ps
module vec_elem_move_tb_top;
   localparam int VW = 256;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic          in_op = 1'b0;
   logic [1:0]    in_size = 2'b00;
   logic [2:0]    in_imm = 3'd0;
   logic [VW-1:0] src_vec = '0;
   logic [VW-1:0] old_dst = '0;
   logic          out_valid;
   logic [VW-1:0] out_result;

   int n_checks = 0;
   int n_errors = 0;
   logic          exp_valid = 1'b0;
   logic [VW-1:0] exp_result = '0;

   always #2.5 clk = ~clk;

   vec_elem_move dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
      .in_size(in_size), .in_imm(in_imm), .src_vec(src_vec), .old_dst(old_dst),
      .out_valid(out_valid), .out_result(out_result)
   );

   function automatic logic [VW-1:0] ref_model(input logic op, input logic [1:0] sz,
         input logic [2:0] imm, input logic [VW-1:0] s, input logic [VW-1:0] d);
      int w, n, k;
      logic [VW-1:0] r;
      if (sz == 2'b00) begin w = 32; n = 8; end
      else if (sz == 2'b01) begin w = 64; n = 4; end
      else return d;
      k = int'(imm) % n;
      if (!op) begin
         r = d;
         for (int b = 0; b < w; b++) r[k*w + b] = s[b];
      end else begin
         r = '0;
         for (int b = 0; b < w; b++) r[b] = s[k*w + b];
      end
      return r;
   endfunction

   function automatic logic [VW-1:0] rand_vec();
      logic [VW-1:0] v;
      for (int i = 0; i < VW/32; i++) v[i*32 +: 32] = $urandom;
      return v;
   endfunction

   function automatic logic [VW-1:0] walk_vec(input logic [7:0] tagb);
      logic [VW-1:0] v;
      for (int i = 0; i < VW/8; i++) v[i*8 +: 8] = tagb ^ 8'(i);
      return v;
   endfunction

   task automatic compare(input string tag);
      n_checks++;
      if (out_valid !== exp_valid || out_result !== exp_result) begin
         n_errors++;
         $display("FAIL %s: actual valid=%0b result=%h expected valid=%0b result=%h",
                  tag, out_valid, out_result, exp_valid, exp_result);
      end
   endtask

   // drive at negedge, model updates at the capturing edge, compare at next negedge
   task automatic step(input logic v, input logic op, input logic [1:0] sz,
         input logic [2:0] imm, input logic [VW-1:0] s, input logic [VW-1:0] d,
         input string tag);
      in_valid = v; in_op = op; in_size = sz; in_imm = imm; src_vec = s; old_dst = d;
      @(posedge clk);
      exp_valid = v;
      if (v) exp_result = ref_model(op, sz, imm, s, d);
      @(negedge clk);
      compare(tag);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_errors++;
      n_checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin : stim
      logic [VW-1:0] a, b;
      repeat (3) @(negedge clk);
      compare("R1 in reset");
      rst_n = 1'b1;
      @(negedge clk);
      compare("R1 after release");
      step(1'b0, 1'b1, 2'b00, 3'd5, rand_vec(), rand_vec(), "R1 idle after reset");

      a = walk_vec(8'h10); b = walk_vec(8'hA0);
      for (int i = 0; i < 8; i++) step(1'b1, 1'b0, 2'b00, 3'(i), a, b, "R3 word insert sweep");
      for (int i = 0; i < 8; i++) step(1'b1, 1'b0, 2'b01, 3'(i), a, b, "R4 dword insert sweep imm2");
      for (int i = 0; i < 8; i++) step(1'b1, 1'b1, 2'b00, 3'(i), a, rand_vec(), "R5 word pick sweep");
      for (int i = 0; i < 8; i++) step(1'b1, 1'b1, 2'b01, 3'(i), a, rand_vec(), "R6 dword pick sweep imm2");
      step(1'b1, 1'b0, 2'b10, 3'd3, a, b, "R7 size 10 insert");
      step(1'b1, 1'b1, 2'b11, 3'd1, a, b, "R7 size 11 pick");
      step(1'b1, 1'b1, 2'b10, 3'd7, a, b, "R7 size 10 pick");

      step(1'b1, 1'b1, 2'b00, 3'd6, a, b, "R2 back to back first");
      step(1'b1, 1'b0, 2'b01, 3'd2, b, a, "R2 back to back second");
      step(1'b0, 1'b1, 2'b11, 3'd4, rand_vec(), rand_vec(), "R8 hold idle 1");
      step(1'b0, 1'b0, 2'b00, 3'd0, rand_vec(), rand_vec(), "R8 hold idle 2");
      step(1'b1, 1'b0, 2'b00, 3'd1, '0, {VW{1'b1}}, "R3 zero into ones");

      a = walk_vec(8'h55);
      step(1'b1, 1'b0, 2'b00, 3'd7, a, a, "R9 aliased word insert");
      step(1'b1, 1'b0, 2'b01, 3'd3, a, a, "R9 aliased dword insert");
      step(1'b1, 1'b0, 2'b00, 3'd0, a, a, "R9 aliased insert slot 0");

      for (int i = 0; i < 400; i++) begin
         step(($urandom % 4) != 0, 1'($urandom), 2'($urandom), 3'($urandom),
              rand_vec(), rand_vec(), "R2 R3 R4 R5 R6 R7 R8 random");
      end

      rst_n = 1'b0;
      #1;
      exp_valid = 1'b0; exp_result = '0;
      compare("R1 mid-run reset");
      @(negedge clk);
      rst_n = 1'b1;

      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end
endmodule